// File: doc/BRIEF.md
# Boot ROM Nibble-Assembly Sequencer

This block answers bus reads aimed at a fixed bootstrap page. Its program store is a ROM only four bits wide. A read therefore walks a four-state sequencer. Each state presents one nibble-select code to the ROM and captures that nibble into its own holding register. The ROM word index stays fixed for the whole read. Once all four nibbles are held, the assembled value is placed on an active-low 16-bit data bus. It goes out either as a whole word, or as a single byte chosen by the low address bit.

A pair of boot-device switches chooses one of two tape units. While the online line is low, the switches force the lowest four data lines to a unit code. Every bus line is active low. Releasing the bus is modelled as all lines high.

The sequencer advances only on a common step strobe, so an outside timing source sets the pace of the nibble fetches. The read ends when the address strobe falls. The bus is released on the next clock.

Top module: `boot_rom_seq`

## Requirements
- R1: After a synchronous active-low reset, `drive_en` is 0 and `data_n` is all ones. The read logic waits for a new read.
- R2: A read starts at a clock edge only if all of these hold: `addr_strobe` is high, the true address (inverse of `bus_addr_n`) has bits 15:8 equal to 8'hFE, and `reload_req` and `intr_req` are both low. If any of these fails, the bus is never driven for that strobe.
- R3: After the start edge, the sequencer passes through four nibble states in fixed order. In state k (k = 1..4), it reads the ROM at word index = true address bits 7:1 captured at start, with select code k-1. It does not drive the bus before the fourth nibble is captured.
- R4: A nibble state captures its nibble and advances only on a clock edge where `step_en` is high. With `step_en` low it holds both state and register contents.
- R5: The ROM nibble at word index i with select s equals (3*i + 7*s + 5) mod 16.
- R6: In word mode (`byte_sel_n` high), the driven bus is the inverse of {nibble4, nibble3, nibble2, nibble1}, with nibble 1 on bits 3:0.
- R7: In byte mode (`byte_sel_n` low), `data_n[15:8]` stays all ones. The low byte is the inverse of {nibble2, nibble1} when captured address bit 0 is 0, and of {nibble4, nibble3} when it is 1.
- R8: The bus is driven (`drive_en` high) only after all four nibbles are held, while `addr_strobe` is high and both `reload_req` and `intr_req` are low. Otherwise `data_n` is all ones.
- R9: While driving with `online_n` low, the switches override `data_n[3:0]`. `boot_unit_sw` = 2'b00 (unit 1) forces 4'b1111. 2'b01 (unit 2) forces 4'b1101, so only line 1 is low. Any setting with bit 1 set leaves the data unchanged.
- R10: When `addr_strobe` falls, at any point of a read, the block returns to waiting on the next edge and releases the bus.
- R11: Changes on `bus_addr_n` after the start edge have no effect on the data of that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr_n | input | 16 | Bus address, active low |
| addr_strobe | input | 1 | Master address strobe, active high |
| reload_req | input | 1 | Reload request; blocks start and drive |
| intr_req | input | 1 | Interrupt request; blocks start and drive |
| step_en | input | 1 | Common nibble step strobe |
| byte_sel_n | input | 1 | Low selects byte mode, high selects word mode |
| boot_unit_sw | input | 2 | Boot unit switches (bit 1 first switch, bit 0 second; 0 = down) |
| online_n | input | 1 | Online line, active low |
| data_n | output | 16 | Data bus, active low, all ones when released |
| drive_en | output | 1 | High while the block drives the data bus |

## Verification
The unit override and the byte-mode steering both act on data lines 3:0, and they can act in the same cycle. The bench provokes this with byte reads at odd and even addresses while `online_n` is low under both unit settings. It judges the result by requiring the high byte to be released, lines 7:4 to come from the selected nibble pair, and lines 3:0 to carry the unit code. A second collision occurs when a step pulse arrives on the same edge that `addr_strobe` falls. The bench requires the abort to win: nothing is driven, and the next read returns correct data.

// File: rtl/boot_seq_pkg.sv
// Package: shared state type and ROM content rule for the boot nibble sequencer.
// Assumes four nibbles per word; select code equals nibble number minus one.
package boot_seq_pkg;

    typedef enum logic [2:0] {
        ST_WAIT = 3'd0,
        ST_NIB1 = 3'd1,
        ST_NIB2 = 3'd2,
        ST_NIB3 = 3'd3,
        ST_NIB4 = 3'd4,
        ST_FULL = 3'd5
    } seq_state_t;

    // Content rule of the bootstrap store: one nibble per (index, select).
    function automatic logic [3:0] rom_nibble(input int unsigned idx, input int unsigned sel);
        int unsigned v;
        v = (idx * 3 + sel * 7 + 5) % 16;
        return v[3:0];
    endfunction

endpackage

// File: rtl/boot_addr_match.sv
// Module: recognises the bootstrap page on the active-low address lines.
// Assumes the page is identified by the address bits from PAGE_LSB upward.
module boot_addr_match #(
    parameter int ADDR_W   = 16,
    parameter int PAGE_LSB = 8,
    parameter logic [ADDR_W-PAGE_LSB-1:0] BOOT_PAGE = '1
) (
    input  logic [ADDR_W-1:0] bus_addr_n,
    output logic              page_hit
);

    localparam int PAGE_W = ADDR_W - PAGE_LSB;

    logic [PAGE_W-1:0] page_true;

    // Invert the active-low page bits and compare with the boot page.
    always_comb begin
        page_true = ~bus_addr_n[ADDR_W-1:PAGE_LSB];
        page_hit  = (page_true == BOOT_PAGE);
    end

endmodule

// File: rtl/boot_nibble_rom.sv
// Module: 4-bit wide bootstrap ROM addressed by word index and nibble select.
// Assumes the output may be zero whenever the enable is low.
module boot_nibble_rom #(
    parameter int IDX_W = 7,
    parameter int SEL_W = 2,
    parameter int NIB_W = 4
) (
    input  logic             rom_en,
    input  logic [IDX_W-1:0] word_idx,
    input  logic [SEL_W-1:0] nib_sel,
    output logic [NIB_W-1:0] nib_out
);

    import boot_seq_pkg::*;

    localparam int AW    = IDX_W + SEL_W;
    localparam int DEPTH = 1 << AW;

    logic [NIB_W-1:0] rom_tbl [DEPTH];
    logic [AW-1:0]    rom_addr;

    // Fill each location from the content rule.
    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        assign rom_tbl[i] = NIB_W'(rom_nibble(i / (1 << SEL_W), i % (1 << SEL_W)));
    end

    // Select the addressed nibble; output forced low while disabled.
    always_comb begin
        rom_addr = {word_idx, nib_sel};
        nib_out  = rom_en ? rom_tbl[rom_addr] : '0;
    end

endmodule

// File: rtl/boot_seq_fsm.sv
// Module: four-state nibble sequencer with per-state gated capture strobes.
// Assumes start is asserted only from the waiting state; strobe loss aborts.
module boot_seq_fsm #(
    parameter int NIB_CNT = 4,
    parameter int SEL_W   = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic                        addr_strobe,
    input  logic                        step_en,
    output boot_seq_pkg::seq_state_t    seq_state,
    output logic [SEL_W-1:0]            nib_sel,
    output logic [NIB_CNT-1:0]          cap_en,
    output logic                        rom_en,
    output logic                        full
);

    import boot_seq_pkg::*;

    seq_state_t state_q, state_d;
    logic       in_nib;

    // Next-state choice: start, step, abort on strobe loss, finish.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT: if (start) state_d = ST_NIB1;
            ST_NIB1: if (!addr_strobe) state_d = ST_WAIT; else if (step_en) state_d = ST_NIB2;
            ST_NIB2: if (!addr_strobe) state_d = ST_WAIT; else if (step_en) state_d = ST_NIB3;
            ST_NIB3: if (!addr_strobe) state_d = ST_WAIT; else if (step_en) state_d = ST_NIB4;
            ST_NIB4: if (!addr_strobe) state_d = ST_WAIT; else if (step_en) state_d = ST_FULL;
            ST_FULL: if (!addr_strobe) state_d = ST_WAIT;
            default: state_d = ST_WAIT;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_WAIT;
        else        state_q <= state_d;
    end

    // Select code and ROM enable follow the active nibble state.
    always_comb begin
        in_nib  = (state_q == ST_NIB1) || (state_q == ST_NIB2) ||
                  (state_q == ST_NIB3) || (state_q == ST_NIB4);
        rom_en  = in_nib;
        nib_sel = in_nib ? SEL_W'(int'(state_q) - int'(ST_NIB1)) : '0;
        full    = (state_q == ST_FULL);
    end

    // One gated capture strobe per nibble state.
    for (genvar k = 0; k < NIB_CNT; k++) begin : g_cap
        assign cap_en[k] = (int'(state_q) == int'(ST_NIB1) + k) && step_en && addr_strobe;
    end

    assign seq_state = state_q;

endmodule

// File: rtl/boot_bus_steer.sv
// Module: word/byte steering, unit override and release of the data bus.
// Assumes the assembled word is true-polarity; output lines are active low.
module boot_bus_steer #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] word_true,
    input  logic              byte_sel_n,
    input  logic              odd_byte,
    input  logic              drive,
    input  logic              online_n,
    input  logic [1:0]        boot_unit_sw,
    output logic [DATA_W-1:0] data_n
);

    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] true_v;
    logic [DATA_W-1:0] bus_v;

    // Pick word or byte, invert, apply unit code, release when idle.
    always_comb begin
        if (byte_sel_n) true_v = word_true;
        else true_v = {{HALF_W{1'b0}},
                       odd_byte ? word_true[DATA_W-1:HALF_W] : word_true[HALF_W-1:0]};
        bus_v = ~true_v;
        if (!online_n) begin
            if (boot_unit_sw == 2'b00)      bus_v[3:0] = 4'b1111;
            else if (boot_unit_sw == 2'b01) bus_v[3:0] = 4'b1101;
        end
        data_n = drive ? bus_v : '1;
    end

endmodule

// File: rtl/boot_rom_seq.sv
// Module: top of the boot ROM nibble-assembly sequencer.
// Assumes the read is held by addr_strobe and paced by step_en.
module boot_rom_seq #(
    parameter int ADDR_W   = 16,
    parameter int PAGE_LSB = 8,
    parameter logic [ADDR_W-PAGE_LSB-1:0] BOOT_PAGE = 8'hFE,
    parameter int NIB_W    = 4,
    parameter int NIB_CNT  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_addr_n,
    input  logic                       addr_strobe,
    input  logic                       reload_req,
    input  logic                       intr_req,
    input  logic                       step_en,
    input  logic                       byte_sel_n,
    input  logic [1:0]                 boot_unit_sw,
    input  logic                       online_n,
    output logic [NIB_W*NIB_CNT-1:0]   data_n,
    output logic                       drive_en
);

    import boot_seq_pkg::*;

    localparam int DATA_W = NIB_W * NIB_CNT;
    localparam int SEL_W  = $clog2(NIB_CNT);
    localparam int IDX_W  = PAGE_LSB - 1;

    logic                  page_hit;
    logic                  start;
    logic [PAGE_LSB-1:0]   addr_lo_q;
    seq_state_t            seq_state;
    logic [SEL_W-1:0]      nib_sel;
    logic [NIB_CNT-1:0]    cap_en;
    logic                  rom_en;
    logic                  full;
    logic [NIB_W-1:0]      rom_nib;
    logic [NIB_W-1:0]      nib_q [NIB_CNT];
    logic [DATA_W-1:0]     word_true;

    boot_addr_match #(
        .ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB), .BOOT_PAGE(BOOT_PAGE)
    ) u_match (
        .bus_addr_n(bus_addr_n), .page_hit(page_hit)
    );

    // Start condition for a new read.
    always_comb begin
        start = (seq_state == ST_WAIT) && addr_strobe && page_hit && !reload_req && !intr_req;
    end

    // Capture the low address bits once at start; held for the whole read.
    always_ff @(posedge clk) begin
        if (!rst_n)     addr_lo_q <= '0;
        else if (start) addr_lo_q <= ~bus_addr_n[PAGE_LSB-1:0];
    end

    boot_seq_fsm #(
        .NIB_CNT(NIB_CNT), .SEL_W(SEL_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .addr_strobe(addr_strobe),
        .step_en(step_en), .seq_state(seq_state), .nib_sel(nib_sel),
        .cap_en(cap_en), .rom_en(rom_en), .full(full)
    );

    boot_nibble_rom #(
        .IDX_W(IDX_W), .SEL_W(SEL_W), .NIB_W(NIB_W)
    ) u_rom (
        .rom_en(rom_en), .word_idx(addr_lo_q[PAGE_LSB-1:1]),
        .nib_sel(nib_sel), .nib_out(rom_nib)
    );

    // Holding registers, one per nibble, each loaded by its own strobe.
    for (genvar k = 0; k < NIB_CNT; k++) begin : g_hold
        always_ff @(posedge clk) begin
            if (!rst_n)         nib_q[k] <= '0;
            else if (cap_en[k]) nib_q[k] <= rom_nib;
        end
        assign word_true[k*NIB_W +: NIB_W] = nib_q[k];
    end

    // Drive only with all nibbles held and the bus conditions met.
    always_comb begin
        drive_en = full && addr_strobe && !reload_req && !intr_req;
    end

    boot_bus_steer #(
        .DATA_W(DATA_W)
    ) u_steer (
        .word_true(word_true), .byte_sel_n(byte_sel_n), .odd_byte(addr_lo_q[0]),
        .drive(drive_en), .online_n(online_n), .boot_unit_sw(boot_unit_sw),
        .data_n(data_n)
    );

endmodule

// File: rtl/boot_rom_seq_chk.sv
// Module: property checker bound to boot_rom_seq.
// Assumes it observes ports plus the sequencer state of the top.
module boot_rom_seq_chk #(
    parameter int DATA_W = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     addr_strobe,
    input logic                     reload_req,
    input logic                     intr_req,
    input logic                     step_en,
    input logic                     byte_sel_n,
    input logic [1:0]               boot_unit_sw,
    input logic                     online_n,
    input logic [DATA_W-1:0]        data_n,
    input logic                     drive_en,
    input boot_seq_pkg::seq_state_t seq_state
);

    import boot_seq_pkg::*;

    // R8
    released_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_en |-> (data_n == '1));

    // R8
    drive_conditions_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en |-> (addr_strobe && !reload_req && !intr_req && seq_state == ST_FULL));

    // R10
    strobe_fall_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(addr_strobe) |-> (seq_state == ST_WAIT) || !drive_en);

    // R10
    abort_to_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_strobe && seq_state != ST_WAIT) |=> (seq_state == ST_WAIT));

    // R4
    hold_without_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state inside {ST_NIB1, ST_NIB2, ST_NIB3, ST_NIB4} && addr_strobe && !step_en)
        |=> $stable(seq_state));

    // R7
    byte_high_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_en && !byte_sel_n) |-> (data_n[DATA_W-1:DATA_W/2] == '1));

    // R9
    unit1_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_en && !online_n && boot_unit_sw == 2'b00) |-> (data_n[3:0] == 4'b1111));

    // R9
    unit2_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_en && !online_n && boot_unit_sw == 2'b01) |-> (data_n[3:0] == 4'b1101));

    // R2
    no_start_without_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_WAIT && !addr_strobe) |=> (seq_state == ST_WAIT));

endmodule

bind boot_rom_seq boot_rom_seq_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/boot_rom_seq_bench.sv
// Bench: vector table walk plus directed reset and corner-case tests.
module boot_rom_seq_bench;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [15:0] addr;
        logic        byte_n;
        logic [1:0]  sw;
        logic        online_n;
        logic        reload;
        logic        exp_drive;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{16'hFE02, 1'b1, 2'b10, 1'b1, 1'b0, 1'b1},
        '{16'hFE57, 1'b0, 2'b10, 1'b1, 1'b0, 1'b1},
        '{16'hFE56, 1'b0, 2'b11, 1'b1, 1'b0, 1'b1},
        '{16'hFE10, 1'b1, 2'b00, 1'b0, 1'b0, 1'b1},
        '{16'hFE20, 1'b1, 2'b01, 1'b0, 1'b0, 1'b1},
        '{16'hFE31, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1},
        '{16'hFE8C, 1'b0, 2'b01, 1'b0, 1'b0, 1'b1},
        '{16'hFD10, 1'b1, 2'b10, 1'b1, 1'b0, 1'b0},
        '{16'hFE44, 1'b1, 2'b10, 1'b1, 1'b1, 1'b0},
        '{16'hFE66, 1'b1, 2'b10, 1'b0, 1'b0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] bus_addr_n;
    logic        addr_strobe, reload_req, intr_req, step_en, byte_sel_n, online_n;
    logic [1:0]  boot_unit_sw;
    logic [15:0] data_n;
    logic        drive_en;

    int total = 0;
    int bad   = 0;

    boot_rom_seq u_boot_rom_seq (
        .clk(clk), .rst_n(rst_n), .bus_addr_n(bus_addr_n), .addr_strobe(addr_strobe),
        .reload_req(reload_req), .intr_req(intr_req), .step_en(step_en),
        .byte_sel_n(byte_sel_n), .boot_unit_sw(boot_unit_sw), .online_n(online_n),
        .data_n(data_n), .drive_en(drive_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ROM content rule from R5.
    function automatic logic [3:0] exp_nib(logic [15:0] a, int k);
        int v;
        v = (int'(a[7:1]) * 3 + k * 7 + 5) % 16;
        return v[3:0];
    endfunction

    // Expected bus value from R6, R7, R9.
    function automatic logic [15:0] exp_bus(logic [15:0] a, logic bn, logic [1:0] sw, logic onl);
        logic [15:0] w, t, b;
        w = {exp_nib(a, 3), exp_nib(a, 2), exp_nib(a, 1), exp_nib(a, 0)};
        t = bn ? w : {8'h00, a[0] ? w[15:8] : w[7:0]};
        b = ~t;
        if (!onl && sw == 2'b00) b[3:0] = 4'b1111;
        if (!onl && sw == 2'b01) b[3:0] = 4'b1101;
        return b;
    endfunction

    task automatic check(string req, logic [16:0] act, logic [16:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Begin a read at a negedge; one posedge moves it into nibble state 1.
    task automatic begin_read(logic [15:0] a);
        bus_addr_n  = ~a;
        addr_strobe = 1'b1;
        @(negedge clk);
    endtask

    task automatic step_n(int n);
        for (int i = 0; i < n; i++) begin
            step_en = 1'b1;
            @(negedge clk);
        end
        step_en = 1'b0;
    endtask

    task automatic end_read();
        addr_strobe = 1'b0;
        bus_addr_n  = '1;
        @(negedge clk);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        rst_n = 1'b0; bus_addr_n = '1; addr_strobe = 0; reload_req = 0; intr_req = 0;
        step_en = 0; byte_sel_n = 1; boot_unit_sw = 2'b10; online_n = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", {drive_en, data_n}, {1'b0, 16'hFFFF});

        // Vector walk: R2 R3 R5 R6 R7 R9
        for (int v = 0; v < NVEC; v++) begin
            byte_sel_n   = VECS[v].byte_n;
            boot_unit_sw = VECS[v].sw;
            online_n     = VECS[v].online_n;
            reload_req   = VECS[v].reload;
            begin_read(VECS[v].addr);
            step_n(4);
            if (VECS[v].exp_drive)
                check("R3/R5/R6/R7/R9 vector", {drive_en, data_n},
                      {1'b1, exp_bus(VECS[v].addr, VECS[v].byte_n, VECS[v].sw, VECS[v].online_n)});
            else
                check("R2 no drive", {drive_en, data_n}, {1'b0, 16'hFFFF});
            end_read();
            reload_req = 0;
            // R10: released after strobe drop
            check("R10 release", {drive_en, data_n}, {1'b0, 16'hFFFF});
        end

        byte_sel_n = 1; boot_unit_sw = 2'b10; online_n = 1;

        // R4: no step, no progress
        begin_read(16'hFE2A);
        repeat (3) @(negedge clk);
        step_n(3);
        check("R4 not full after 3 steps", {16'h0, drive_en}, 17'h0);
        step_n(1);
        check("R4 R3 full after 4th step", {drive_en, data_n},
              {1'b1, exp_bus(16'hFE2A, 1'b1, 2'b10, 1'b1)});
        end_read();

        // R11: address change during the read is ignored
        begin_read(16'hFE7E);
        step_n(1);
        bus_addr_n = ~16'hFE01;
        step_n(3);
        check("R11 address held", {drive_en, data_n},
              {1'b1, exp_bus(16'hFE7E, 1'b1, 2'b10, 1'b1)});
        // R8: interrupt request blocks drive, removal restores it
        intr_req = 1'b1;
        #1;
        check("R8 intr blocks", {drive_en, data_n}, {1'b0, 16'hFFFF});
        intr_req = 1'b0;
        #1;
        check("R8 intr removed", {drive_en, data_n},
              {1'b1, exp_bus(16'hFE7E, 1'b1, 2'b10, 1'b1)});
        // R9: online rising removes override
        boot_unit_sw = 2'b00; online_n = 1'b0;
        #1;
        check("R9 unit1 override", {drive_en, data_n},
              {1'b1, exp_bus(16'hFE7E, 1'b1, 2'b00, 1'b0)});
        online_n = 1'b1;
        #1;
        check("R9 online high", {drive_en, data_n},
              {1'b1, exp_bus(16'hFE7E, 1'b1, 2'b00, 1'b1)});
        boot_unit_sw = 2'b10;
        @(negedge clk);
        end_read();

        // R10: abort mid-read, step on the same edge as strobe drop
        begin_read(16'hFE40);
        step_n(2);
        addr_strobe = 1'b0; step_en = 1'b1;
        @(negedge clk);
        step_en = 1'b0;
        addr_strobe = 1'b1;
        @(negedge clk);
        check("R10 abort no drive", {drive_en, data_n}, {1'b0, 16'hFFFF});
        end_read();
        begin_read(16'hFE40);
        step_n(4);
        check("R10 read after abort", {drive_en, data_n},
              {1'b1, exp_bus(16'hFE40, 1'b1, 2'b10, 1'b1)});
        end_read();

        // R1: reset mid-read returns to idle
        begin_read(16'hFE12);
        step_n(4);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset while driving", {drive_en, data_n}, {1'b0, 16'hFFFF});
        end_read();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule